// File: doc/BRIEF.md
# AXI4 Slave Block RAM Controller

This block is an AXI4 memory-mapped slave in front of a single-port on-chip RAM. The RAM has the same data width as the bus. The slave accepts write and read bursts. It turns each AXI byte address into a RAM word address by dropping the byte-lane offset bits and every bit above the configured range, so the served window always starts at zero. An interconnect can place the window at any base address without any change to the block.

The write engine and the read engine each run their own burst. They share the single RAM port through a two-way round-robin arbiter. An uncontended burst issues one RAM access per clock. The RAM output feeds the read data channel directly, with its native one-cycle latency and no extra pipeline register. A read stall holds back further RAM reads, and the RAM output register keeps the pending beat.

Top module: `axi_ram_ctrl`

## Requirements
- R1: After reset, aw_ready_o and ar_ready_o are 1, and b_valid_o and r_valid_o are 0.
- R2: The RAM word address is byte-address bits [log2(DATA_W/8)+log2(DEPTH)-1 : log2(DATA_W/8)]. The bits below that range (the lane offset) and the bits above it are ignored, so 0xA000_0044, 0x44 and 0x47 all reach the same word when DATA_W=32 and DEPTH=256.
- R3: Write strobe bit i enables byte lane i (data bits [8i+7:8i]). Lanes whose strobe is 0 keep their old content.
- R4: A burst carries aw_len_i+1 (or ar_len_i+1) beats. Burst code 2'b01 (incrementing) advances the word address by one per beat, modulo DEPTH.
- R5: Burst code 2'b00 (fixed) uses the start word for every beat. Code 2'b10 is served the same way as incrementing.
- R6: During a write burst with no pending read, w_ready_o is high in every cycle in which w_valid_i is high, so one RAM write happens per clock.
- R7: Exactly one write response follows the last data beat, with b_resp_o = 2'b00. b_valid_o stays high until b_ready_i is seen, and drops after the handshake.
- R8: With r_ready_i held high and no contending write, an N-beat read burst delivers its N beats on N consecutive cycles. The first beat is valid one cycle after the read address is accepted.
- R9: While r_valid_o is high and r_ready_i is low, r_valid_o, r_data_o and r_last_o hold steady. No beat is lost or repeated under stalls.
- R10: r_last_o is high only on the final beat of a read burst, and r_resp_o is 2'b00 on every beat.
- R11: The RAM port performs at most one access per cycle. When reads and writes both request it, they alternate, and both bursts complete with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_addr_i | input | ADDR_W | Write burst start byte address |
| aw_len_i | input | 8 | Write beats minus one |
| aw_burst_i | input | 2 | Write burst kind (00 fixed, 01 incr, 10 as incr) |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_o | output | 1 | Write address accepted |
| w_data_i | input | DATA_W | Write data |
| w_strb_i | input | DATA_W/8 | Byte-lane write enables |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data accepted |
| b_resp_o | output | 2 | Write response code |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Write response accepted |
| ar_addr_i | input | ADDR_W | Read burst start byte address |
| ar_len_i | input | 8 | Read beats minus one |
| ar_burst_i | input | 2 | Read burst kind |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address accepted |
| r_data_o | output | DATA_W | Read data |
| r_resp_o | output | 2 | Read response code |
| r_last_o | output | 1 | Final read beat |
| r_valid_o | output | 1 | Read data valid |
| r_ready_i | input | 1 | Read data accepted |

## Verification
The bench builds the block with a 32-bit address, a 32-bit data path and a depth of 256 words, which gives a 1 KB window. With these values, an address carrying 0xA000_0000 in its upper bits lands inside the window, and offsets within a word can be shown to alias to one word. The small depth also keeps every tested burst disjoint and cheap to cross-check against a byte-wide reference model. Four byte lanes give enough strobe patterns to show lane merging across separate writes and within a fixed burst.

// File: rtl/axi_ram_pkg.sv
package axi_ram_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10
  } burst_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic addr_steps(input logic [1:0] kind);
    return kind != BURST_FIXED;
  endfunction
endpackage

// File: rtl/axi_ram_arb.sv
module axi_ram_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_w_i,
  input  logic req_r_i,
  output logic gnt_w_o,
  output logic gnt_r_o
);
  logic pref_r_q;

  assign gnt_w_o = req_w_i && (!req_r_i || !pref_r_q);
  assign gnt_r_o = req_r_i && (!req_w_i || pref_r_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pref_r_q <= 1'b0;
    else if (req_w_i && req_r_i) pref_r_q <= !pref_r_q;
  end

  // R11
  rr_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_w_i && req_r_i && gnt_w_o) ##1 (req_w_i && req_r_i) |-> gnt_r_o);
endmodule

// File: rtl/axi_ram_mem.sv
module axi_ram_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int BYTES = DATA_W / 8,
  localparam int WA_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [WA_W-1:0]   addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BYTES-1:0]  be_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] lane_q [DEPTH];
    logic [7:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) lane_q[addr_i] <= wdata_i[g*8 +: 8];
      if (re_i)            rd_q <= lane_q[addr_i];
    end
    assign rdata_o[g*8 +: 8] = rd_q;
  end

  // R11
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
endmodule

// File: rtl/axi_ram_wr.sv
module axi_ram_wr
  import axi_ram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF   = $clog2(BYTES),
  localparam int WA_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] aw_addr_i,
  input  logic [7:0]        aw_len_i,
  input  logic [1:0]        aw_burst_i,
  input  logic              aw_valid_i,
  output logic              aw_ready_o,
  input  logic              w_valid_i,
  output logic              w_ready_o,
  output logic [1:0]        b_resp_o,
  output logic              b_valid_o,
  input  logic              b_ready_i,
  output logic              req_o,
  input  logic              gnt_i,
  output logic [WA_W-1:0]   mem_addr_o
);
  typedef enum logic [1:0] {WR_IDLE, WR_DATA, WR_RESP} wr_state_e;

  wr_state_e       state_q;
  logic [WA_W-1:0] addr_q;
  logic [8:0]      left_q;
  logic [1:0]      kind_q;
  logic            unused_aw_bits;

  assign unused_aw_bits = ^aw_addr_i;
  assign aw_ready_o = state_q == WR_IDLE;
  assign req_o      = state_q == WR_DATA && w_valid_i;
  assign w_ready_o  = gnt_i;
  assign b_valid_o  = state_q == WR_RESP;
  assign b_resp_o   = RESP_OKAY;
  assign mem_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      kind_q  <= BURST_INCR;
    end else begin
      unique case (state_q)
        WR_IDLE: if (aw_valid_i) begin
          addr_q  <= aw_addr_i[OFF +: WA_W];
          left_q  <= {1'b0, aw_len_i} + 9'd1;
          kind_q  <= aw_burst_i;
          state_q <= WR_DATA;
        end
        WR_DATA: if (gnt_i) begin
          left_q <= left_q - 9'd1;
          if (addr_steps(kind_q)) addr_q <= addr_q + 1'b1;
          if (left_q == 9'd1) state_q <= WR_RESP;
        end
        WR_RESP: if (b_ready_i) state_q <= WR_IDLE;
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  // R7
  bresp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_o && !b_ready_i |=> b_valid_o);
  // R4
  beat_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == WR_DATA && gnt_i && left_q != 9'd1 |=> state_q == WR_DATA && !b_valid_o);
  // R5
  fixed_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == WR_DATA && kind_q == BURST_FIXED && gnt_i |=> $stable(mem_addr_o));
endmodule

// File: rtl/axi_ram_rd.sv
module axi_ram_rd
  import axi_ram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF   = $clog2(BYTES),
  localparam int WA_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ar_addr_i,
  input  logic [7:0]        ar_len_i,
  input  logic [1:0]        ar_burst_i,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  output logic [1:0]        r_resp_o,
  output logic              r_last_o,
  output logic              r_valid_o,
  input  logic              r_ready_i,
  output logic              req_o,
  input  logic              gnt_i,
  output logic [WA_W-1:0]   mem_addr_o
);
  logic            busy_q, vld_q, last_q;
  logic [WA_W-1:0] addr_q;
  logic [8:0]      left_q;
  logic [1:0]      kind_q;
  logic            unused_ar_bits;

  assign unused_ar_bits = ^ar_addr_i;
  assign ar_ready_o = !busy_q;
  // issue only when the RAM output register is free or being drained
  assign req_o      = busy_q && left_q != 9'd0 && (!vld_q || r_ready_i);
  assign mem_addr_o = addr_q;
  assign r_valid_o  = vld_q;
  assign r_last_o   = last_q;
  assign r_resp_o   = RESP_OKAY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      kind_q <= BURST_INCR;
    end else if (!busy_q) begin
      if (ar_valid_i) begin
        busy_q <= 1'b1;
        addr_q <= ar_addr_i[OFF +: WA_W];
        left_q <= {1'b0, ar_len_i} + 9'd1;
        kind_q <= ar_burst_i;
      end
    end else if (gnt_i) begin
      left_q <= left_q - 9'd1;
      if (addr_steps(kind_q)) addr_q <= addr_q + 1'b1;
      vld_q  <= 1'b1;
      last_q <= left_q == 9'd1;
    end else if (vld_q && r_ready_i) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      if (last_q) busy_q <= 1'b0;
    end
  end

  // R10
  rlast_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_last_o |-> r_valid_o);
  // R10
  rlast_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && r_ready_i && r_last_o |=> !r_valid_o && ar_ready_o);
endmodule

// File: rtl/axi_ram_ctrl.sv
module axi_ram_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int BYTES = DATA_W / 8,
  localparam int WA_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] aw_addr_i,
  input  logic [7:0]        aw_len_i,
  input  logic [1:0]        aw_burst_i,
  input  logic              aw_valid_i,
  output logic              aw_ready_o,
  input  logic [DATA_W-1:0] w_data_i,
  input  logic [BYTES-1:0]  w_strb_i,
  input  logic              w_valid_i,
  output logic              w_ready_o,
  output logic [1:0]        b_resp_o,
  output logic              b_valid_o,
  input  logic              b_ready_i,
  input  logic [ADDR_W-1:0] ar_addr_i,
  input  logic [7:0]        ar_len_i,
  input  logic [1:0]        ar_burst_i,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  output logic [DATA_W-1:0] r_data_o,
  output logic [1:0]        r_resp_o,
  output logic              r_last_o,
  output logic              r_valid_o,
  input  logic              r_ready_i
);
  logic            req_w, req_r, gnt_w, gnt_r;
  logic [WA_W-1:0] wr_addr, rd_addr, mem_addr;

  axi_ram_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
    .clk_i, .rst_ni,
    .aw_addr_i, .aw_len_i, .aw_burst_i, .aw_valid_i, .aw_ready_o,
    .w_valid_i, .w_ready_o,
    .b_resp_o, .b_valid_o, .b_ready_i,
    .req_o(req_w), .gnt_i(gnt_w), .mem_addr_o(wr_addr)
  );

  axi_ram_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk_i, .rst_ni,
    .ar_addr_i, .ar_len_i, .ar_burst_i, .ar_valid_i, .ar_ready_o,
    .r_resp_o, .r_last_o, .r_valid_o, .r_ready_i,
    .req_o(req_r), .gnt_i(gnt_r), .mem_addr_o(rd_addr)
  );

  axi_ram_arb u_arb (
    .clk_i, .rst_ni,
    .req_w_i(req_w), .req_r_i(req_r), .gnt_w_o(gnt_w), .gnt_r_o(gnt_r)
  );

  assign mem_addr = gnt_w ? wr_addr : rd_addr;

  axi_ram_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni,
    .we_i(gnt_w), .re_i(gnt_r), .addr_i(mem_addr),
    .wdata_i(w_data_i), .be_i(w_strb_i), .rdata_o(r_data_o)
  );

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i |=> r_valid_o && $stable(r_data_o) && $stable(r_last_o));
endmodule

// File: tb/axi_ram_ctrl_bench.sv
module axi_ram_ctrl_bench;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 256;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] aw_addr = '0, ar_addr = '0, w_data = '0;
  logic [7:0]  aw_len = '0, ar_len = '0;
  logic [1:0]  aw_burst = '0, ar_burst = '0;
  logic [3:0]  w_strb = '0;
  logic        aw_valid = 0, w_valid = 0, b_ready = 0, ar_valid = 0, r_ready = 0;
  logic        aw_ready, w_ready, b_valid, ar_ready, r_last, r_valid;
  logic [1:0]  b_resp, r_resp;
  logic [31:0] r_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0]  ref_mem [DEPTH*4];
  logic [31:0] wbuf [16];
  logic [3:0]  sbuf [16];

  always #5 clk = ~clk;

  axi_ram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_axi_ram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .aw_addr_i(aw_addr), .aw_len_i(aw_len), .aw_burst_i(aw_burst),
    .aw_valid_i(aw_valid), .aw_ready_o(aw_ready),
    .w_data_i(w_data), .w_strb_i(w_strb), .w_valid_i(w_valid), .w_ready_o(w_ready),
    .b_resp_o(b_resp), .b_valid_o(b_valid), .b_ready_i(b_ready),
    .ar_addr_i(ar_addr), .ar_len_i(ar_len), .ar_burst_i(ar_burst),
    .ar_valid_i(ar_valid), .ar_ready_o(ar_ready),
    .r_data_o(r_data), .r_resp_o(r_resp), .r_last_o(r_last),
    .r_valid_o(r_valid), .r_ready_i(r_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int word_of(input logic [31:0] a, input int beat, input logic [1:0] bt);
    return ((a >> 2) + (bt != 2'b00 ? beat : 0)) % DEPTH;
  endfunction

  function automatic logic [31:0] ref_word(input int w);
    return {ref_mem[w*4+3], ref_mem[w*4+2], ref_mem[w*4+1], ref_mem[w*4]};
  endfunction

  // all tasks start and end 1 time unit after a rising edge
  task automatic wr_burst(input logic [31:0] a, input int len, input logic [1:0] bt,
                          input bit stall, input bit timed, input int bdelay);
    aw_addr = a; aw_len = 8'(len - 1); aw_burst = bt; aw_valid = 1;
    do @(negedge clk); while (!aw_ready);
    @(posedge clk); #1 aw_valid = 0;
    for (int i = 0; i < len; i++) begin
      int waits = 0;
      if (stall) repeat ($urandom % 3) begin @(posedge clk); #1; end
      w_data = wbuf[i]; w_strb = sbuf[i]; w_valid = 1;
      @(negedge clk);
      while (!w_ready && waits < 50) begin waits++; @(negedge clk); end
      @(posedge clk); #1 w_valid = 0;
      for (int b = 0; b < 4; b++)
        if (sbuf[i][b]) ref_mem[word_of(a, i, bt)*4+b] = wbuf[i][b*8 +: 8];
      if (timed) chk(waits == 0, "R6 wready every cycle", waits, 0);
    end
    for (int d = 0; d < bdelay; d++) begin
      @(negedge clk);
      chk(b_valid, "R7 bvalid held", b_valid, 1);
      @(posedge clk); #1;
    end
    b_ready = 1;
    @(negedge clk);
    chk(b_valid && b_resp == 2'b00, "R7 bresp okay", {b_valid, b_resp}, 3'b100);
    @(posedge clk); #1 b_ready = 0;
    @(negedge clk);
    chk(!b_valid, "R7 single response", b_valid, 0);
    @(posedge clk); #1;
  endtask

  task automatic rd_burst(input logic [31:0] a, input int len, input logic [1:0] bt,
                          input bit stall, input bit timed);
    int got = 0, cyc = 0;
    bit held = 0;
    logic [31:0] hold_d = '0;
    logic hold_l = 0;
    ar_addr = a; ar_len = 8'(len - 1); ar_burst = bt; ar_valid = 1;
    do @(negedge clk); while (!ar_ready);
    @(posedge clk); #1 ar_valid = 0;
    while (got < len && cyc < 8*len + 40) begin
      @(posedge clk); #1 r_ready = stall ? ($urandom % 3 != 0) : 1'b1;
      @(negedge clk); cyc++;
      if (held) chk(r_valid && r_data == hold_d && r_last == hold_l,
                    "R9 stalled beat stable", r_data, hold_d);
      held = 0;
      if (r_valid) begin
        if (r_ready) begin
          logic [31:0] e;
          e = ref_word(word_of(a, got, bt));
          chk(r_data == e, "R4 R5 read data", r_data, e);
          chk(r_last == (got == len - 1), "R10 rlast position", r_last, got == len - 1);
          chk(r_resp == 2'b00, "R10 rresp okay", r_resp, 0);
          got++;
        end else begin
          held = 1; hold_d = r_data; hold_l = r_last;
        end
      end
    end
    chk(got == len, "R9 beat count", got, len);
    if (timed) chk(cyc == len, "R8 back-to-back beats", cyc, len);
    @(posedge clk); #1 r_ready = 0;
    @(negedge clk);
    chk(!r_valid, "R9 no extra beat", r_valid, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(aw_ready && ar_ready && !b_valid && !r_valid, "R1 reset state",
        {aw_ready, ar_ready, b_valid, r_valid}, 4'b1100);
    @(posedge clk); #1;
  endtask

  task automatic t_strobe();
    wbuf[0] = 32'h1234_5678; sbuf[0] = 4'hF;
    wr_burst(32'h20, 1, 2'b01, 0, 0, 0);
    rd_burst(32'h20, 1, 2'b01, 0, 1);
    wbuf[0] = 32'hAABB_CCDD; sbuf[0] = 4'hF;
    wr_burst(32'h30, 1, 2'b01, 0, 0, 0);
    wbuf[0] = 32'h1122_3344; sbuf[0] = 4'b0101;
    wr_burst(32'h30, 1, 2'b01, 0, 0, 1);
    chk(ref_word(12) == 32'hAA22_CC44, "R3 model merge", ref_word(12), 32'hAA22_CC44);
    rd_burst(32'h30, 1, 2'b01, 0, 1); // R3 lanes kept
  endtask

  task automatic t_incr();
    for (int i = 0; i < 8; i++) begin wbuf[i] = 32'hC0DE_0000 + i * 32'h111; sbuf[i] = 4'hF; end
    wr_burst(32'h100, 8, 2'b01, 0, 1, 3); // R4 R6 R7
    rd_burst(32'h100, 8, 2'b01, 0, 1);    // R8 R10
  endtask

  task automatic t_fixed();
    wbuf[0] = 32'h0000_00A1; sbuf[0] = 4'b0001;
    wbuf[1] = 32'h0000_B200; sbuf[1] = 4'b0010;
    wbuf[2] = 32'h00C3_0000; sbuf[2] = 4'b0100;
    wbuf[3] = 32'hD400_0000; sbuf[3] = 4'b1000;
    wr_burst(32'h200, 4, 2'b00, 0, 1, 0);
    chk(ref_word(128) == 32'hD4C3_B2A1, "R5 fixed model", ref_word(128), 32'hD4C3_B2A1);
    rd_burst(32'h200, 3, 2'b00, 0, 1); // R5 fixed read
    for (int i = 0; i < 2; i++) begin wbuf[i] = 32'h5A5A_0000 + i; sbuf[i] = 4'hF; end
    wr_burst(32'h380, 2, 2'b10, 0, 1, 0); // R5 code 10 as incr
    rd_burst(32'h380, 2, 2'b01, 0, 1);
  endtask

  task automatic t_upper();
    wbuf[0] = 32'hFEED_BEEF; sbuf[0] = 4'hF;
    wr_burst(32'hA000_0044, 1, 2'b01, 0, 0, 0); // R2
    rd_burst(32'h0000_0044, 1, 2'b01, 0, 1);
    rd_burst(32'h0000_0047, 1, 2'b01, 0, 1);   // R2 offset ignored
    rd_burst(32'h5500_0044, 1, 2'b01, 0, 1);
  endtask

  task automatic t_stall();
    for (int i = 0; i < 16; i++) begin wbuf[i] = $urandom; sbuf[i] = 4'(i | 1); end
    wr_burst(32'h240, 16, 2'b01, 1, 0, 2);
    rd_burst(32'h240, 16, 2'b01, 1, 0); // R9
  endtask

  task automatic t_conc();
    for (int i = 0; i < 8; i++) begin wbuf[i] = 32'h7700_0000 | i; sbuf[i] = 4'hF; end
    fork
      wr_burst(32'h300, 8, 2'b01, 0, 0, 0); // R11
      rd_burst(32'h100, 8, 2'b01, 0, 0);    // R11
    join
    rd_burst(32'h300, 8, 2'b01, 0, 1);      // R11 write landed
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_strobe();
    t_incr();
    t_fixed();
    t_upper();
    t_stall();
    t_conc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule